// File: doc/BRIEF.md
# Double-Buffered Serial Master Shifter

This block is a clocked serial master. Each transfer shifts one word out on `mosi` while it shifts one word in from `miso`, with the serial clock `sclk` driven by the block. A one-word holding register sits in front of the shift stage. The host can therefore queue the next word while the current one is still on the wire. In continuous mode the queued word follows the current one with no break in the serial clock.

On the host side, words enter through a transmit port with valid/ready. The port has no stall semantics. `tx_ready` is high while the holding register is empty. The host must hold back `tx_valid` until it sees `tx_ready`. A word offered while `tx_ready` is low is dropped, and the sticky `tx_overrun` flag is set. Received words appear on `rx_data`, which is valid when `irq_rx_done` pulses and holds until the next such pulse. The receive side has no back-pressure. The next `irq_tx_free` pulse tells the host that the holding register has space again.

Configuration inputs set the word length, the bit order, the clock polarity and phase, the clock divider and continuous mode. They must stay stable while `busy` is high.

Top module: `spim_master`

## Requirements
- R1: After reset the block is idle: `busy`=0, `tx_ready`=1, both interrupt outputs are 0, `tx_overrun`=0, and `sclk` rests at `cfg_mode[1]`.
- R2: A word offered with `tx_valid` while `tx_ready`=1 is taken at that clock edge. After that edge `busy`=1 and `tx_ready`=0. From idle, the transfer starts one clock later.
- R3: During a transfer `sclk` toggles every `cfg_div`+1 system clocks. With `cfg_div`=0 the serial clock runs at half the system clock.
- R4: A transfer carries `cfg_len`+1 bits (1 to MAX_W) and produces exactly 2·(`cfg_len`+1) `sclk` toggles. Bits of `tx_data` above that length are not sent. Bits of `rx_data` above that length read 0.
- R5: With `cfg_lsb_first`=0, bit `cfg_len` goes first and bit 0 last. With `cfg_lsb_first`=1, bit 0 goes first. Received bits are placed at the same positions, in the same order.
- R6: `cfg_mode[1]` is the idle level of `sclk`. With `cfg_mode[0]`=0, the first bit is on `mosi` before the first edge, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With `cfg_mode[0]`=1, `mosi` changes on leading edges and `miso` is sampled on trailing edges. Mode 0 idles low and samples on the rising edge.
- R7: `irq_tx_free` is a one-cycle pulse, raised when the held word moves into the shifter. While it is high, `tx_ready`=1.
- R8: `irq_rx_done` is a one-cycle pulse, raised at the clock edge that makes the last `sclk` toggle of a word. `rx_data` changes only at that edge.
- R9: With `cfg_cont`=1, a word queued before the current word ends makes its first `sclk` toggle `cfg_div`+1 clocks after the last toggle of the current word, so the clock period is uniform across the boundary.
- R10: With `cfg_cont`=0, a queued word waits in idle. Its first toggle comes 2·(`cfg_div`+1)+1 clocks after the last toggle of the previous word.
- R11: A word offered while `tx_ready`=0 is discarded and never transmitted. `tx_overrun` becomes 1 and stays 1 until reset.
- R12: When a word ends and no word is queued, `busy` falls at the same edge as `irq_rx_done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | MAX_W | Transmit word |
| tx_ready | output | 1 | Holding register empty |
| rx_data | output | MAX_W | Last received word |
| cfg_len | input | $clog2(MAX_W) | Word length minus one |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_mode | input | 2 | [1] clock idle level, [0] clock phase |
| cfg_div | input | DIV_W | Half-period of sclk minus one, in system clocks |
| cfg_cont | input | 1 | Continuous back-to-back mode |
| busy | output | 1 | Transfer running or word queued |
| tx_overrun | output | 1 | Sticky: a word was dropped |
| irq_tx_free | output | 1 | Holding register freed (pulse) |
| irq_rx_done | output | 1 | Word received (pulse) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench places each result in a fixed cycle:
- After an accepted write, `busy` and `tx_ready` change one clock later.
- From idle, `irq_tx_free` follows one clock after that.
- `irq_rx_done` and the final `sclk` toggle come from the same edge. The bench checks this by timing the last toggle against the negative edge at which the pulse is first seen: the gap must be half a system clock.

Inputs are driven on negative edges and outputs are sampled on negative edges. Clock spacing is measured from the timestamps of every `sclk` toggle, against `cfg_div`+1 within a word. At word boundaries the expected spacing is `cfg_div`+1 in continuous mode and 2·(`cfg_div`+1)+1 otherwise. A serial slave model in the bench drives `miso` on shift edges and records `mosi` on sample edges, following the mode.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_XFER = 1'b1} spim_state_e;
endpackage

// File: rtl/spim_holdbuf.sv
`timescale 1ns/1ps
// One-word transmit holding register with drop-on-full policy.
module spim_holdbuf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data,
  output logic         overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      data    <= '0;
      overrun <= 1'b0;
    end else if (full) begin
      if (take)     full    <= 1'b0;
      if (wr_valid) overrun <= 1'b1;
    end else if (wr_valid) begin
      full <= 1'b1;
      data <= wr_data;
    end
  end
endmodule

// File: rtl/spim_baud.sv
`timescale 1ns/1ps
// Half-period timer: tick every (div+1) clocks, realigned by restart.
module spim_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
// Bit-indexed shift stage: edge counter selects the bit being driven or sampled.
module spim_shifter #(
  parameter  int MAX_W = 16,
  localparam int LW    = $clog2(MAX_W),
  localparam int EW    = LW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             edge_i,
  input  logic [MAX_W-1:0] din,
  input  logic [LW-1:0]    cfg_len,
  input  logic             cfg_lsb,
  input  logic             cfg_cpha,
  input  logic             miso,
  output logic             mosi,
  output logic             last,
  output logic [MAX_W-1:0] rx_data
);
  logic [MAX_W-1:0] word_q, rx_q, rx_nxt;
  logic [EW-1:0]    e_q;
  logic [LW-1:0]    len_q, b, first;
  logic             lsb_q, cpha_q, mosi_q, lead, smp, at_end;

  function automatic logic [LW-1:0] pos(input logic [LW-1:0] k);
    return lsb_q ? k : (len_q - k);
  endfunction

  assign b      = e_q[EW-1:1];
  assign lead   = ~e_q[0];
  assign smp    = lead ^ cpha_q;
  assign at_end = (e_q == {len_q, 1'b1});
  assign last   = edge_i && at_end;
  assign first  = cfg_lsb ? '0 : cfg_len;
  assign mosi   = mosi_q;

  always_comb begin
    rx_nxt = rx_q;
    if (edge_i && smp) rx_nxt[pos(b)] = miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      rx_q   <= '0;
      e_q    <= '0;
      len_q  <= '0;
      lsb_q  <= 1'b0;
      cpha_q <= 1'b0;
      mosi_q <= 1'b0;
    end else if (load) begin
      word_q <= din;
      rx_q   <= '0;
      e_q    <= '0;
      len_q  <= cfg_len;
      lsb_q  <= cfg_lsb;
      cpha_q <= cfg_cpha;
      if (!cfg_cpha) mosi_q <= din[first];
    end else if (edge_i) begin
      rx_q <= rx_nxt;
      e_q  <= e_q + 1'b1;
      if (!cpha_q && !lead && !at_end) mosi_q <= word_q[pos(b + 1'b1)];
      if (cpha_q && lead)              mosi_q <= word_q[pos(b)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rx_data <= '0;
    else if (last) rx_data <= rx_nxt;
  end
endmodule

// File: rtl/spim_master.sv
`timescale 1ns/1ps
module spim_master
  import spim_pkg::*;
#(
  parameter  int MAX_W = 16,
  parameter  int DIV_W = 8,
  localparam int LW    = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  input  logic [MAX_W-1:0] tx_data,
  output logic             tx_ready,
  output logic [MAX_W-1:0] rx_data,
  input  logic [LW-1:0]    cfg_len,
  input  logic             cfg_lsb_first,
  input  logic [1:0]       cfg_mode,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cont,
  output logic             busy,
  output logic             tx_overrun,
  output logic             irq_tx_free,
  output logic             irq_rx_done,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  spim_state_e      state_q;
  logic             full, tick, last, load, xfer, edge_s, gap_ok_q;
  logic             sclk_q, irq_tx_q, irq_rx_q;
  logic [MAX_W-1:0] hold_data;

  assign xfer   = (state_q == ST_XFER);
  assign edge_s = tick && xfer;
  assign load   = full && ((!xfer && gap_ok_q) || (last && cfg_cont));

  spim_holdbuf #(.W(MAX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_valid(tx_valid), .wr_data(tx_data),
    .take(load), .full(full), .data(hold_data), .overrun(tx_overrun)
  );

  spim_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .restart(load), .div(cfg_div), .tick(tick)
  );

  spim_shifter #(.MAX_W(MAX_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .edge_i(edge_s), .din(hold_data),
    .cfg_len(cfg_len), .cfg_lsb(cfg_lsb_first), .cfg_cpha(cfg_mode[0]),
    .miso(miso), .mosi(mosi), .last(last), .rx_data(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      gap_ok_q <= 1'b1;
      sclk_q   <= 1'b0;
      irq_tx_q <= 1'b0;
      irq_rx_q <= 1'b0;
    end else begin
      irq_tx_q <= load;
      irq_rx_q <= last;
      if (load)      state_q <= ST_XFER;
      else if (last) state_q <= ST_IDLE;
      if (last && !load)    gap_ok_q <= 1'b0;
      else if (!xfer && tick) gap_ok_q <= 1'b1;
      if (!xfer)       sclk_q <= cfg_mode[1];
      else if (edge_s) sclk_q <= ~sclk_q;
    end
  end

  assign tx_ready    = ~full;
  assign busy        = xfer | full;
  assign sclk        = sclk_q;
  assign irq_tx_free = irq_tx_q;
  assign irq_rx_done = irq_rx_q;
endmodule

// File: rtl/spim_master_chk.sv
`timescale 1ns/1ps
module spim_master_chk #(
  parameter int MAX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             busy,
  input logic             tx_overrun,
  input logic             irq_tx_free,
  input logic             irq_rx_done,
  input logic [MAX_W-1:0] rx_data,
  input logic             sclk,
  input logic [1:0]       cfg_mode
);
  logic up_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  a_r2_take_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (busy && !tx_ready));
  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !busy && $past(!busy) && $stable(cfg_mode)) |-> (sclk == cfg_mode[1]));
  a_r7_free_ready: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_free |-> tx_ready);
  a_r7_free_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_free |=> !irq_tx_free);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_done |=> !irq_rx_done);
  a_r8_rx_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> irq_rx_done);
  a_r11_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_overrun);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overrun |=> tx_overrun);
  a_r12_idle_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq_rx_done);
endmodule

bind spim_master spim_master_chk #(.MAX_W(MAX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .busy(busy), .tx_overrun(tx_overrun), .irq_tx_free(irq_tx_free),
  .irq_rx_done(irq_rx_done), .rx_data(rx_data), .sclk(sclk), .cfg_mode(cfg_mode)
);

// File: tb/spim_master_tb.sv
`timescale 1ns/1ps
module spim_master_tb;
  localparam int MAX_W = 16;
  localparam int DIV_W = 8;
  localparam int LW    = $clog2(MAX_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0;
  logic [MAX_W-1:0] tx_data = '0;
  logic tx_ready;
  logic [MAX_W-1:0] rx_data;
  logic [LW-1:0] cfg_len = 4'd7;
  logic cfg_lsb_first = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [DIV_W-1:0] cfg_div = '0;
  logic cfg_cont = 1'b0;
  logic busy, tx_overrun, irq_tx_free, irq_rx_done, sclk, mosi;
  logic miso = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  spim_master #(.MAX_W(MAX_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_data(rx_data), .cfg_len(cfg_len),
    .cfg_lsb_first(cfg_lsb_first), .cfg_mode(cfg_mode), .cfg_div(cfg_div),
    .cfg_cont(cfg_cont), .busy(busy), .tx_overrun(tx_overrun),
    .irq_tx_free(irq_tx_free), .irq_rx_done(irq_rx_done), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  // Serial slave model
  logic   sb [0:127];
  int     s_len = 0, ptr = 0;
  logic   cap [0:127];
  int     cap_n = 0;
  longint et [0:127];
  int     ne = 0;
  longint last_t = 0;
  bit     slv_on = 0;
  int     rx_cnt = 0, tx_cnt = 0;

  always @(sclk) begin
    if (slv_on) begin
      logic lead;
      lead = (sclk != cfg_mode[1]);
      if (ne < 128) et[ne] = $time;
      ne++;
      last_t = $time;
      if (lead == !cfg_mode[0] && cap_n < 128) begin
        cap[cap_n] = mosi;
        cap_n++;
      end
      if (!cfg_mode[0] && !lead) begin
        ptr++;
        miso = sb[ptr];
      end
      if (cfg_mode[0] && lead) begin
        miso = sb[ptr];
        ptr++;
      end
    end
  end

  always @(negedge clk) begin
    if (irq_rx_done) rx_cnt++;
    if (irq_tx_free) tx_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int len, input bit lsb, input logic [1:0] md,
                         input int div, input bit cont);
    slv_on = 0;
    cfg_len = LW'(len - 1);
    cfg_lsb_first = lsb;
    cfg_mode = md;
    cfg_div = DIV_W'(div);
    cfg_cont = cont;
    repeat (3) @(negedge clk);
  endtask

  task automatic s_reset();
    s_len = 0; ptr = 0; cap_n = 0; ne = 0;
  endtask

  task automatic s_push(input logic [MAX_W-1:0] w, input int n, input bit lsb);
    for (int i = 0; i < n; i++) sb[s_len + i] = lsb ? w[i] : w[n-1-i];
    s_len += n;
  endtask

  task automatic s_start();
    if (!cfg_mode[0]) miso = sb[0];
    slv_on = 1;
  endtask

  task automatic wr(input logic [MAX_W-1:0] w);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = w;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx();
    @(negedge clk);
    while (!irq_rx_done) @(negedge clk);
  endtask

  task automatic chk_mosi(input logic [MAX_W-1:0] w, input int n, input bit lsb,
                          input int off, input string tag);
    logic [MAX_W-1:0] got;
    got = '0;
    for (int i = 0; i < n; i++) got[lsb ? i : n-1-i] = cap[off + i];
    chk(got == (w & MAX_W'((1 << n) - 1)), tag, got, w & MAX_W'((1 << n) - 1));
  endtask

  task automatic chk_spacing(input int from, input int to, input longint gap, input string tag);
    bit ok;
    ok = 1;
    for (int i = from; i < to; i++) if (et[i+1] - et[i] != gap) ok = 0;
    chk(ok, tag, (to > from) ? et[from+1] - et[from] : 0, gap);
  endtask

  task automatic t_reset();
    chk(busy == 0 && tx_ready == 1, "R1 busy/ready after reset", {busy, tx_ready}, 2'b01);
    chk(irq_tx_free == 0 && irq_rx_done == 0 && tx_overrun == 0, "R1 flags after reset",
        {irq_tx_free, irq_rx_done, tx_overrun}, 0);
    chk(sclk == 0, "R1 sclk idle", sclk, 0);
  endtask

  task automatic t_basic();
    set_cfg(8, 0, 2'b00, 0, 0);
    s_reset(); s_push(16'h3C, 8, 0); s_start();
    wr(16'h00A5);
    chk(busy == 1 && tx_ready == 0, "R2 busy after write", {busy, tx_ready}, 2'b10);
    @(negedge clk);
    chk(irq_tx_free == 1 && tx_ready == 1, "R7 free pulse on load", {irq_tx_free, tx_ready}, 2'b11);
    chk(sclk == 0 && mosi == 1, "R6 first bit before first edge", {sclk, mosi}, 2'b01);
    @(negedge clk);
    chk(irq_tx_free == 0, "R7 free pulse one cycle", irq_tx_free, 0);
    wait_rx();
    chk(($time - last_t) == 5, "R8 done aligned to final edge", $time - last_t, 5);
    chk(busy == 0, "R12 busy clears with done", busy, 0);
    chk(rx_data == 16'h003C, "R5 msb-first receive", rx_data, 16'h3C);
    chk(ne == 16, "R4 toggle count 8-bit", ne, 16);
    chk_spacing(0, 15, 10, "R3 half-period div0");
    chk_mosi(16'h00A5, 8, 0, 0, "R5 msb-first transmit");
    chk(cap_n == 8, "R6 mode0 sample count", cap_n, 8);
    @(negedge clk);
    chk(irq_rx_done == 0, "R8 done pulse one cycle", irq_rx_done, 0);
    chk(sclk == 0, "R6 mode0 idle low", sclk, 0);
  endtask

  task automatic t_mode3_lsb();
    set_cfg(5, 1, 2'b11, 2, 0);
    chk(sclk == 1, "R6 mode3 idle high", sclk, 1);
    s_reset(); s_push(16'h000D, 5, 1); s_start();
    wr(16'hFF16);
    wait_rx();
    chk(rx_data == 16'h000D, "R4 R5 lsb-first 5-bit receive", rx_data, 16'h000D);
    chk_mosi(16'h0016, 5, 1, 0, "R5 lsb-first transmit");
    chk(ne == 10, "R4 toggle count 5-bit", ne, 10);
    chk_spacing(0, 9, 30, "R3 half-period div2");
    chk(sclk == 1, "R6 mode3 back to idle", sclk, 1);
  endtask

  task automatic t_mode1();
    set_cfg(8, 0, 2'b01, 1, 0);
    s_reset(); s_push(16'h00C3, 8, 0); s_start();
    wr(16'h005A);
    wait_rx();
    chk(rx_data == 16'h00C3, "R6 mode1 receive", rx_data, 16'hC3);
    chk_mosi(16'h005A, 8, 0, 0, "R6 mode1 transmit");
  endtask

  task automatic t_mode2_full();
    set_cfg(16, 0, 2'b10, 0, 0);
    s_reset(); s_push(16'h1234, 16, 0); s_start();
    wr(16'hBEEF);
    wait_rx();
    chk(rx_data == 16'h1234, "R4 16-bit receive mode2", rx_data, 16'h1234);
    chk_mosi(16'hBEEF, 16, 0, 0, "R4 16-bit transmit mode2");
    chk(ne == 32, "R4 toggle count 16-bit", ne, 32);
  endtask

  task automatic t_pair(input bit cont);
    int t0;
    set_cfg(8, 0, 2'b00, 1, cont);
    s_reset(); s_push(16'h0081, 8, 0); s_push(16'h007E, 8, 0); s_start();
    t0 = tx_cnt;
    wr(16'h00F0);
    @(negedge clk);
    while (!irq_tx_free) @(negedge clk);
    chk(tx_ready == 1, cont ? "R7 ready for second word" : "R10 ready for second word", tx_ready, 1);
    wr(16'h000F);
    wait_rx();
    chk(rx_data == 16'h0081, cont ? "R9 first receive" : "R10 first receive", rx_data, 16'h81);
    chk(busy == 1, cont ? "R9 busy held" : "R10 busy held", busy, 1);
    wait_rx();
    chk(rx_data == 16'h007E, cont ? "R9 second receive" : "R10 second receive", rx_data, 16'h7E);
    chk_mosi(16'h00F0, 8, 0, 0, cont ? "R9 first transmit" : "R10 first transmit");
    chk_mosi(16'h000F, 8, 0, 8, cont ? "R9 second transmit" : "R10 second transmit");
    chk(tx_cnt - t0 == 2, "R7 one free pulse per word", tx_cnt - t0, 2);
    chk_spacing(0, 15, 20, cont ? "R9 first word spacing" : "R10 first word spacing");
    chk_spacing(16, 31, 20, cont ? "R9 second word spacing" : "R10 second word spacing");
    if (cont) chk(et[16] - et[15] == 20, "R9 no gap at boundary", et[16] - et[15], 20);
    else      chk(et[16] - et[15] == 50, "R10 idle gap at boundary", et[16] - et[15], 50);
  endtask

  task automatic t_overrun();
    int r0;
    set_cfg(8, 0, 2'b00, 0, 1);
    s_reset(); s_push(16'h0011, 8, 0); s_push(16'h0022, 8, 0); s_push(16'h0033, 8, 0); s_start();
    r0 = rx_cnt;
    wr(16'h00C5);
    @(negedge clk);
    while (!irq_tx_free) @(negedge clk);
    wr(16'h003A);
    chk(tx_ready == 0 && tx_overrun == 0, "R11 full before drop", {tx_ready, tx_overrun}, 2'b00);
    wr(16'h00FF);
    chk(tx_overrun == 1, "R11 overrun set", tx_overrun, 1);
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(rx_cnt - r0 == 2, "R11 dropped word not sent", rx_cnt - r0, 2);
    chk(cap_n == 16, "R11 bit count", cap_n, 16);
    chk_mosi(16'h00C5, 8, 0, 0, "R11 first word intact");
    chk_mosi(16'h003A, 8, 0, 8, "R11 second word intact");
    chk(tx_overrun == 1, "R11 overrun sticky", tx_overrun, 1);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mode3_lsb();
    t_mode1();
    t_mode2_full();
    t_pair(1'b1);
    t_pair(1'b0);
    t_overrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule